// File: doc/BRIEF.md
# Block-Lock Write Guard

This block owns the protection status register of a small serial memory and decides, cycle by cycle, whether a write to the array or to the status register may go ahead. A command controller in front of it presents the target address, a one-cycle array-write request, a one-cycle status-write request with its data byte, and one-cycle pulses for the write-latch and flag commands. The guard returns two allow signals and the assembled status byte that the controller shifts out on a status read.

Two stored lock bits choose how much of the 2 K-byte array, counted from its top, refuses writes. A stored protect-enable bit, combined with an active-low write-protect pin, freezes the status register in a ROM-like mode. An accepted write starts a self-timed busy period. The stored lock bits only change when the busy period of a status write ends, so the pin falling during that write cannot stop it.

Top module: `blklock_guard`

## Requirements
- R1: The status byte is bit 7 protect-enable, bit 6 flag, bits 5:4 zero, bits 3:2 lock code, bit 1 write latch, bit 0 busy. With default parameters it reads 0x00 after reset.
- R2: Lock code 0 protects no address. Code 1 protects 0x600 to 0x7FF. Code 2 protects 0x400 to 0x7FF. Code 3 protects the whole array.
- R3: An array write is allowed only with the latch set, not busy, and the address outside the protected range. A request that is not allowed changes nothing.
- R4: A status write is allowed only with the latch set, not busy, and not (protect-enable = 1 with the pin low). A request that is not allowed changes nothing.
- R5: A status-write request whose data bits 1:0 are not both zero is ignored.
- R6: An accepted write raises busy in the cycle after the request. Busy stays high for exactly WRITE_CYCLES cycles, and the latch is clear when busy falls.
- R7: Protect-enable and the lock code take the written values (data bit 7, bits 3:2) in the cycle busy falls, not earlier. A pin change during that busy period does not cancel them.
- R8: Bits 5:4 read zero and the flag is unchanged, whatever data a status write carries.
- R9: Latch-set and latch-clear pulses set and clear the latch, and flag-set and flag-clear pulses do the same for the flag. When set and clear arrive together, clear wins.
- R10: While busy, latch and flag commands and all write requests are ignored.
- R11: A status-write request in the same cycle as an array-write request causes the array request to be ignored, even if the status request is itself rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| wp_n_i | input | 1 | Write-protect pin, low = protect |
| addr_i | input | ADDR_W | Array address of the pending write |
| mem_wr_req_i | input | 1 | One-cycle array-write request |
| sr_wr_req_i | input | 1 | One-cycle status-write request |
| sr_data_i | input | 8 | Status-write data byte |
| wel_set_i | input | 1 | Set write latch |
| wel_clr_i | input | 1 | Clear write latch |
| flag_set_i | input | 1 | Set flag |
| flag_clr_i | input | 1 | Clear flag |
| mem_wr_ok_o | output | 1 | Array write at addr_i allowed now |
| sr_wr_ok_o | output | 1 | Status write allowed now |
| status_o | output | 8 | Assembled status byte |

## Verification
The bench walks the lock codes across the address boundaries at 0x3FF/0x400 and 0x5FF/0x600. A decoder off by one quarter, or one that counts from the bottom of the array, would allow a write just inside a protected range. It drops the pin in the middle of a status write: a design that samples the pin at completion would lose the new lock bits. A design that commits at acceptance would show them early. It sends a latch-clear during busy, which a design without the busy gate would obey. It sends a status request with nonzero low bits alongside an array request, which a design with the wrong priority would let through as an array write.

// File: rtl/blklock_pkg.sv
package blklock_pkg;

   localparam int SR_W        = 8;
   localparam int BIT_PE      = 7;
   localparam int BIT_FLAG    = 6;
   localparam int BIT_LOCK_HI = 3;
   localparam int BIT_LOCK_LO = 2;
   localparam int BIT_WEL     = 1;
   localparam int BIT_BUSY    = 0;

   typedef struct packed {
      logic       pe;
      logic [1:0] lock;
   } nv_bits_t;

endpackage

// File: rtl/blklock_decode.sv
module blklock_decode #(
   parameter int ADDR_W = 11
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [1:0]        lock_i,
   output logic              prot_o
);
   localparam int          CMP_W = ADDR_W + 1;
   localparam logic [CMP_W-1:0] SIZE = CMP_W'(1) << ADDR_W;

   initial begin
      assert (ADDR_W >= 2) else $error("blklock_decode: ADDR_W must be at least 2");
   end

   logic [3:0] hit;
   assign hit[0] = 1'b0;

   for (genvar c = 1; c < 4; c++) begin : g_code
      localparam logic [CMP_W-1:0] SPAN  = (c == 3) ? SIZE : (SIZE >> (3 - c));
      localparam logic [CMP_W-1:0] FLOOR = SIZE - SPAN;
      assign hit[c] = ({1'b0, addr_i} >= FLOOR);
   end

   assign prot_o = hit[lock_i];
endmodule

// File: rtl/blklock_timer.sv
module blklock_timer #(
   parameter int WRITE_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o,
   output logic done_o
);
   localparam int CNT_W = (WRITE_CYCLES > 1) ? $clog2(WRITE_CYCLES) : 1;
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(WRITE_CYCLES - 1);

   initial begin
      assert (WRITE_CYCLES >= 1) else $error("blklock_timer: WRITE_CYCLES must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (busy_q) begin
         if (cnt_q == '0) busy_q <= 1'b0;
         else             cnt_q  <= cnt_q - 1'b1;
      end else if (start_i) begin
         busy_q <= 1'b1;
         cnt_q  <= LOAD;
      end
   end

   assign busy_o = busy_q;
   assign done_o = busy_q && (cnt_q == '0);

   AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !done_o) |=> busy_q); // R6
endmodule

// File: rtl/blklock_srlock.sv
module blklock_srlock
   import blklock_pkg::*;
#(
   parameter nv_bits_t NV_INIT = '0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wel_i,
   input  logic           busy_i,
   input  logic           done_i,
   input  logic           wp_n_i,
   input  logic           req_i,
   input  logic [SR_W-1:0] data_i,
   output logic           ok_o,
   output logic           accept_o,
   output nv_bits_t       nv_o
);
   nv_bits_t nv_q, pend_q;
   logic     pend_vld_q;
   logic     locked;

   assign locked   = nv_q.pe && !wp_n_i;
   assign ok_o     = wel_i && !busy_i && !locked;
   assign accept_o = req_i && ok_o && (data_i[1:0] == 2'b00);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nv_q       <= NV_INIT;
         pend_q     <= '0;
         pend_vld_q <= 1'b0;
      end else begin
         if (accept_o) begin
            pend_q     <= '{pe: data_i[BIT_PE], lock: data_i[BIT_LOCK_HI:BIT_LOCK_LO]};
            pend_vld_q <= 1'b1;
         end else if (done_i) begin
            pend_vld_q <= 1'b0;
            if (pend_vld_q) nv_q <= pend_q;
         end
      end
   end

   assign nv_o = nv_q;

   AST_NV_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(busy_i) |-> $stable(nv_q)); // R7
   AST_LOCK_RESPECTED: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy_i) && $past(req_i)) |-> $past(!(nv_q.pe && !wp_n_i))); // R4
endmodule

// File: rtl/blklock_guard.sv
module blklock_guard
   import blklock_pkg::*;
#(
   parameter int       ADDR_W       = 11,
   parameter int       WRITE_CYCLES = 8,
   parameter nv_bits_t NV_INIT      = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wp_n_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              mem_wr_req_i,
   input  logic              sr_wr_req_i,
   input  logic [7:0]        sr_data_i,
   input  logic              wel_set_i,
   input  logic              wel_clr_i,
   input  logic              flag_set_i,
   input  logic              flag_clr_i,
   output logic              mem_wr_ok_o,
   output logic              sr_wr_ok_o,
   output logic [7:0]        status_o
);
   logic     wel_q, flag_q;
   logic     busy, done, prot;
   logic     sr_accept, mem_accept;
   nv_bits_t nv;

   blklock_decode #(.ADDR_W(ADDR_W)) u_decode (
      .addr_i (addr_i),
      .lock_i (nv.lock),
      .prot_o (prot)
   );

   blklock_timer #(.WRITE_CYCLES(WRITE_CYCLES)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (sr_accept || mem_accept),
      .busy_o  (busy),
      .done_o  (done)
   );

   blklock_srlock #(.NV_INIT(NV_INIT)) u_srlock (
      .clk      (clk),
      .rst_n    (rst_n),
      .wel_i    (wel_q),
      .busy_i   (busy),
      .done_i   (done),
      .wp_n_i   (wp_n_i),
      .req_i    (sr_wr_req_i),
      .data_i   (sr_data_i),
      .ok_o     (sr_wr_ok_o),
      .accept_o (sr_accept),
      .nv_o     (nv)
   );

   assign mem_wr_ok_o = wel_q && !busy && !prot;
   assign mem_accept  = mem_wr_req_i && mem_wr_ok_o && !sr_wr_req_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel_q  <= 1'b0;
         flag_q <= 1'b0;
      end else if (busy) begin
         if (done) wel_q <= 1'b0;
      end else begin
         if (wel_clr_i)       wel_q <= 1'b0;
         else if (wel_set_i)  wel_q <= 1'b1;
         if (flag_clr_i)      flag_q <= 1'b0;
         else if (flag_set_i) flag_q <= 1'b1;
      end
   end

   always_comb begin
      status_o                          = '0;
      status_o[BIT_PE]                  = nv.pe;
      status_o[BIT_FLAG]                = flag_q;
      status_o[BIT_LOCK_HI:BIT_LOCK_LO] = nv.lock;
      status_o[BIT_WEL]                 = wel_q;
      status_o[BIT_BUSY]                = busy;
   end

   AST_BUSY_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(wel_q)); // R3
   AST_WEL_DROP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !wel_q); // R6
   AST_FLAG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy) |-> $stable(flag_q)); // R10
endmodule

// File: tb/blklock_guard_test.sv
module blklock_guard_test;
   localparam int CLK_PERIOD = 10;
   localparam int WCYC = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wp_n = 1'b1;
   logic [10:0] addr = '0;
   logic        mem_req = 0, sr_req = 0;
   logic [7:0]  sr_data = '0;
   logic        wel_set = 0, wel_clr = 0, flag_set = 0, flag_clr = 0;
   logic        mem_ok, sr_ok;
   logic [7:0]  status;

   int checks = 0;
   int errors = 0;
   bit ended = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   blklock_guard #(.ADDR_W(11), .WRITE_CYCLES(WCYC)) uut (
      .clk(clk), .rst_n(rst_n), .wp_n_i(wp_n), .addr_i(addr),
      .mem_wr_req_i(mem_req), .sr_wr_req_i(sr_req), .sr_data_i(sr_data),
      .wel_set_i(wel_set), .wel_clr_i(wel_clr), .flag_set_i(flag_set),
      .flag_clr_i(flag_clr), .mem_wr_ok_o(mem_ok), .sr_wr_ok_o(sr_ok),
      .status_o(status)
   );

   // fields: pe[17] lock[16:15] wp_n[14] wel[13] addr[12:2] mem_ok[1] sr_ok[0]
   localparam logic [17:0] VEC [0:9] = '{
      {1'b0, 2'b00, 1'b1, 1'b1, 11'h7FF, 1'b1, 1'b1},
      {1'b0, 2'b01, 1'b1, 1'b1, 11'h5FF, 1'b1, 1'b1},
      {1'b0, 2'b01, 1'b1, 1'b1, 11'h600, 1'b0, 1'b1},
      {1'b0, 2'b10, 1'b0, 1'b1, 11'h3FF, 1'b1, 1'b1},
      {1'b0, 2'b10, 1'b1, 1'b1, 11'h400, 1'b0, 1'b1},
      {1'b0, 2'b11, 1'b1, 1'b1, 11'h000, 1'b0, 1'b1},
      {1'b1, 2'b00, 1'b0, 1'b1, 11'h123, 1'b1, 1'b0},
      {1'b1, 2'b01, 1'b1, 1'b1, 11'h123, 1'b1, 1'b1},
      {1'b1, 2'b10, 1'b0, 1'b0, 11'h000, 1'b0, 1'b0},
      {1'b0, 2'b00, 1'b1, 1'b0, 11'h000, 1'b0, 1'b0}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cycle();
      @(negedge clk);
      #1;
   endtask

   task automatic pulse_wren();
      wel_set = 1; cycle(); wel_set = 0;
   endtask

   task automatic wait_idle();
      while (status[0]) cycle();
   endtask

   task automatic program_sr(input logic [7:0] d);
      wp_n = 1;
      pulse_wren();
      sr_data = d; sr_req = 1; cycle(); sr_req = 0;
      wait_idle();
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      cycle(); cycle();
      // R1 reset state, R3 nothing allowed with the latch clear
      check("R1 reset status", status, 8'h00);
      check("R3 reset mem_ok", mem_ok, 0);
      check("R4 reset sr_ok", sr_ok, 0);
      rst_n = 1; cycle();

      // R2/R3/R4/R1 table walk
      for (int i = 0; i < 10; i++) begin
         logic [17:0] v;
         v = VEC[i];
         program_sr({v[17], 1'b0, 2'b00, v[16:15], 2'b00});
         if (v[13]) pulse_wren();
         wp_n = v[14]; addr = v[12:2]; #1;
         check($sformatf("R2/R3 vec%0d mem_ok", i), mem_ok, v[1]);
         check($sformatf("R4 vec%0d sr_ok", i), sr_ok, v[0]);
         check($sformatf("R1 vec%0d status", i), status, {v[17], 1'b0, 2'b00, v[16:15], v[13], 1'b0});
         wel_clr = 1; cycle(); wel_clr = 0;
      end

      // R9 flag and latch commands, clear wins
      flag_set = 1; cycle(); flag_set = 0;
      check("R9 flag set", status[6], 1);
      flag_set = 1; flag_clr = 1; cycle(); flag_set = 0; flag_clr = 0;
      check("R9 flag clear wins", status[6], 0);
      wel_set = 1; wel_clr = 1; cycle(); wel_set = 0; wel_clr = 0;
      check("R9 latch clear wins", status[1], 0);

      // R6/R10 busy length and commands ignored while busy
      program_sr(8'h04);              // lock code 1
      pulse_wren();
      addr = 11'h100; mem_req = 1; cycle(); mem_req = 0;
      check("R6 busy k=1", status[0], 1);
      wel_clr = 1; flag_set = 1; cycle(); wel_clr = 0; flag_set = 0;
      check("R10 latch kept while busy", status[1], 1);
      check("R10 flag kept while busy", status[6], 0);
      for (int k = 3; k <= WCYC; k++) cycle();
      check("R6 busy k=WCYC", status[0], 1);
      cycle();
      check("R6 busy ends", status[0], 0);
      check("R6 latch clear at end", status[1], 0);

      // R3 protected address request ignored
      pulse_wren();
      addr = 11'h600; mem_req = 1; cycle(); mem_req = 0;
      check("R3 protected not busy", status[0], 0);
      check("R3 protected latch kept", status[1], 1);

      // R5 nonzero low data bits
      sr_data = 8'h0D; sr_req = 1; cycle(); sr_req = 0;
      check("R5 bad data not busy", status[0], 0);
      check("R5 bad data lock kept", status[3:2], 2'b01);

      // R11 status request blocks array request
      addr = 11'h000; mem_req = 1; sr_req = 1; sr_data = 8'h01; cycle();
      mem_req = 0; sr_req = 0;
      check("R11 array request dropped", status[0], 0);

      // R7/R8 commit at end, pin drop mid-write
      sr_data = 8'hFC; sr_req = 1; cycle(); sr_req = 0;
      check("R7 busy started", status[0], 1);
      check("R7 old nv during busy", {status[7], status[3:2]}, 3'b001);
      wp_n = 0;
      wait_idle();
      check("R7 R8 committed status", status, 8'h8C);

      // R4 locked mode
      pulse_wren();
      check("R4 locked sr_ok", sr_ok, 0);
      sr_data = 8'h00; sr_req = 1; cycle(); sr_req = 0;
      check("R4 locked ignored", status, 8'h8E);
      wp_n = 1; #1;
      check("R4 pin high unlocks", sr_ok, 1);

      finish_run();
   end
endmodule